// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is an 8 KB data cache that sits between a 32-bit processor request port and a slower word-wide memory port. Each request address is split into a line index, a tag and a word select; the indexed entry is read, its stored tag is compared with the upper address bits and, when the entry is valid and the tags agree, the selected word is returned in the same cycle. A read that misses stalls the processor, waits until all buffered writes have reached memory, fetches the four words of the line from memory in ascending order, installs the line and then serves the request as a hit.

Stores never wait for memory. Each accepted store is placed in a four-entry write buffer that drains to memory in acceptance order, and the cached word is updated at the same time if the line is present. A store to an absent line does not allocate it. The processor is stalled on a store only while the buffer holds four entries. Both the tag store (with a per-line valid bit cleared by reset) and the data store are modelled as inferred arrays.

Top module: `wt_dcache`

## Requirements
- R1: Reset clears every valid bit, so the first read of any address after reset is a miss, whatever the tag array holds.
- R2: The address is split as byte offset = bits 3:0, line index = bits 12:4, tag = bits 31:13; two addresses with the same index and different tags evict each other.
- R3: A read hit raises cpu_ready in the same cycle as cpu_req, returns the word chosen by address bits 3:2 on cpu_rdata, and issues no memory read.
- R4: A read miss issues exactly four memory reads at the line base address plus 0, 4, 8 and 12, in that order, installs the line, and then returns the requested word.
- R5: Every accepted write reaches memory exactly once with its address and data, in the order the writes were accepted.
- R6: A write that hits updates the cached word so a later read returns the new value without a miss; a write that misses does not allocate, so a later read of that address misses.
- R7: A write is accepted (cpu_ready high in the request cycle) whenever fewer than four writes are pending, and is stalled while four are pending.
- R8: A read miss issues no memory read while any accepted write has not yet been acknowledged by memory; a read after a buffered write to the same address returns the written data.
- R9: mem_req, once raised, stays high with mem_addr, mem_we and mem_wdata unchanged until mem_ack is seen; address bits 1:0 are ignored and all transfers are full words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Request completes at this rising edge |
| cpu_rdata | output | 32 | Load data, valid while cpu_ready is high for a load |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory word address (byte address, bits 1:0 zero for fills) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the current transfer at this edge |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
Two functions meet in one cycle in this block: a processor store being pushed into the write buffer while memory acknowledges and retires the oldest buffered store, and a store hit writing the data array in the same cycle it enters the buffer. The bench provokes this with a zero-latency memory and back-to-back store hits to one cached line, then judges it by the full write log matching the accepted stores in order and by hit reads returning the new words. A second collision, a read miss arriving while stores are still buffered, is provoked by holding memory off and is judged by the absence of any line read until every buffered store has been acknowledged.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

   // Controller states of the cache
   typedef enum logic [1:0] {
      CST_IDLE  = 2'd0,   // serving hits and accepting stores
      CST_DRAIN = 2'd1,   // read miss pending, waiting for store buffer to empty
      CST_FILL  = 2'd2    // fetching the line word by word
   } ctl_state_e;

endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
   parameter int IDX_W = 9,
   parameter int TAG_W = 19,
   parameter int LINES = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic [TAG_W-1:0] upd_tag
);

   if (LINES != (1 << IDX_W)) begin : g_bad_lines
      $error("wtc_tag_store: LINES must equal 2**IDX_W");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("wtc_tag_store: TAG_W must be at least 1");
   end

   logic [LINES-1:0] line_valid;
   logic [TAG_W-1:0] tag_mem [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_valid <= '0;
      end else if (upd_en) begin
         line_valid[upd_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (upd_en) begin
         tag_mem[upd_idx] <= upd_tag;
      end
   end

   assign lk_hit = line_valid[lk_idx] && (tag_mem[lk_idx] == lk_tag);

   // A line just installed must be found by a lookup of the same index and tag
   assert_install_visible_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && lk_idx == upd_idx && lk_tag == upd_tag) |=>
         ((lk_idx != $past(upd_idx)) || (lk_tag != $past(upd_tag)) || lk_hit));

endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
   parameter int AW = 11,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data
);

   localparam int DEPTH = 1 << AW;

   if (AW < 1) begin : g_bad_aw
      $error("wtc_data_store: AW must be at least 1");
   end

   logic [DW-1:0] word_mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         word_mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data = word_mem[rd_addr];

endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic          full,
   output logic          empty,
   output logic [AW-1:0] head_addr,
   output logic [DW-1:0] head_data
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("wtc_wbuf: DEPTH must be at least 2");
   end

   logic [AW-1:0]    addr_q [DEPTH];
   logic [DW-1:0]    data_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] fill_lvl;

   // Pointer advance: natural wrap for power-of-two depths, explicit wrap otherwise
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + PTR_W'(1);
      assign rd_nxt = rd_ptr + PTR_W'(1);
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         fill_lvl <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   fill_lvl <= fill_lvl + CNT_W'(1);
            2'b01:   fill_lvl <= fill_lvl - CNT_W'(1);
            default: fill_lvl <= fill_lvl;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         addr_q[wr_ptr] <= push_addr;
         data_q[wr_ptr] <= push_data;
      end
   end

   assign full      = (fill_lvl == CNT_W'(DEPTH));
   assign empty     = (fill_lvl == '0);
   assign head_addr = addr_q[rd_ptr];
   assign head_data = data_q[rd_ptr];

   assert_no_overflow_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   assert_no_underflow_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

   assert_level_bound_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      fill_lvl <= CNT_W'(DEPTH));

endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
   import wtc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_BYTES = 16,
   parameter int NUM_LINES  = 512,
   parameter int WBUF_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int WORD_BYTES = DATA_W / 8;
   localparam int BYTE_W     = $clog2(WORD_BYTES);
   localparam int OFF_W      = $clog2(LINE_BYTES);
   localparam int IDX_W      = $clog2(NUM_LINES);
   localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
   localparam int WORDS      = LINE_BYTES / WORD_BYTES;
   localparam int WSEL_W     = OFF_W - BYTE_W;
   localparam int DADDR_W    = IDX_W + WSEL_W;

   // Elaboration-time parameter checks
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("wt_dcache: LINE_BYTES must be a power of two");
   end
   if ((NUM_LINES & (NUM_LINES - 1)) != 0) begin : g_bad_lines
      $error("wt_dcache: NUM_LINES must be a power of two");
   end
   if (WORDS < 2) begin : g_bad_words
      $error("wt_dcache: a line must hold at least two words");
   end
   if (DATA_W % 8 != 0) begin : g_bad_dw
      $error("wt_dcache: DATA_W must be a whole number of bytes");
   end
   if (TAG_W < 1) begin : g_bad_split
      $error("wt_dcache: address too narrow for index and offset");
   end

   // Address fields of the request
   logic [IDX_W-1:0]  cpu_idx;
   logic [TAG_W-1:0]  cpu_tag;
   logic [WSEL_W-1:0] cpu_wsel;
   logic              unused_low_bits;

   assign cpu_idx         = cpu_addr[OFF_W +: IDX_W];
   assign cpu_tag         = cpu_addr[ADDR_W-1 -: TAG_W];
   assign cpu_wsel        = cpu_addr[BYTE_W +: WSEL_W];
   assign unused_low_bits = ^cpu_addr[BYTE_W-1:0];

   // Controller state
   ctl_state_e        state_q, state_nx;
   logic [WSEL_W-1:0] fill_cnt;
   logic [IDX_W-1:0]  miss_idx;
   logic [TAG_W-1:0]  miss_tag;

   // Store buffer signals
   logic              wb_full, wb_empty, wb_push, wb_pop;
   logic [ADDR_W-1:0] wb_head_addr;
   logic [DATA_W-1:0] wb_head_data;

   // Lookup and data store signals
   logic               lk_hit;
   logic               is_idle;
   logic               rd_hit_ok, wr_take, rd_miss_start;
   logic               fill_beat, fill_last;
   logic               ds_wr_en;
   logic [DADDR_W-1:0] ds_wr_addr;
   logic [DATA_W-1:0]  ds_wr_data;
   logic [DATA_W-1:0]  ds_rd_data;

   assign is_idle       = (state_q == CST_IDLE);
   assign rd_hit_ok     = is_idle && cpu_req && !cpu_we && lk_hit;
   assign rd_miss_start = is_idle && cpu_req && !cpu_we && !lk_hit;
   assign wr_take       = is_idle && cpu_req && cpu_we && !wb_full;
   assign cpu_ready     = rd_hit_ok || wr_take;
   assign cpu_rdata     = ds_rd_data;

   assign fill_beat = (state_q == CST_FILL) && mem_ack;
   assign fill_last = fill_beat && (fill_cnt == WSEL_W'(WORDS - 1));

   assign wb_push = wr_take;
   assign wb_pop  = (state_q != CST_FILL) && !wb_empty && mem_ack;

   // Memory port: line fill owns it during FILL, the store buffer otherwise
   always_comb begin
      if (state_q == CST_FILL) begin
         mem_req   = 1'b1;
         mem_we    = 1'b0;
         mem_addr  = {miss_tag, miss_idx, fill_cnt, {BYTE_W{1'b0}}};
         mem_wdata = '0;
      end else begin
         mem_req   = !wb_empty;
         mem_we    = 1'b1;
         mem_addr  = wb_head_addr;
         mem_wdata = wb_head_data;
      end
   end

   // Data store write port: fill beats and store hits never share a cycle
   always_comb begin
      ds_wr_en   = 1'b0;
      ds_wr_addr = {cpu_idx, cpu_wsel};
      ds_wr_data = cpu_wdata;
      if (fill_beat) begin
         ds_wr_en   = 1'b1;
         ds_wr_addr = {miss_idx, fill_cnt};
         ds_wr_data = mem_rdata;
      end else if (wr_take && lk_hit) begin
         ds_wr_en   = 1'b1;
      end
   end

   // Next-state logic
   always_comb begin
      state_nx = state_q;
      unique case (state_q)
         CST_IDLE:  if (rd_miss_start) state_nx = wb_empty ? CST_FILL : CST_DRAIN;
         CST_DRAIN: if (wb_empty)      state_nx = CST_FILL;
         CST_FILL:  if (fill_last)     state_nx = CST_IDLE;
         default:                      state_nx = CST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= CST_IDLE;
         fill_cnt <= '0;
         miss_idx <= '0;
         miss_tag <= '0;
      end else begin
         state_q <= state_nx;
         if (rd_miss_start) begin
            miss_idx <= cpu_idx;
            miss_tag <= cpu_tag;
            fill_cnt <= '0;
         end else if (fill_beat) begin
            fill_cnt <= fill_cnt + WSEL_W'(1);
         end
      end
   end

   wtc_tag_store #(
      .IDX_W (IDX_W),
      .TAG_W (TAG_W),
      .LINES (NUM_LINES)
   ) i_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_idx  (cpu_idx),
      .lk_tag  (cpu_tag),
      .lk_hit  (lk_hit),
      .upd_en  (fill_last),
      .upd_idx (miss_idx),
      .upd_tag (miss_tag)
   );

   wtc_data_store #(
      .AW (DADDR_W),
      .DW (DATA_W)
   ) i_data (
      .clk     (clk),
      .rd_addr ({cpu_idx, cpu_wsel}),
      .rd_data (ds_rd_data),
      .wr_en   (ds_wr_en),
      .wr_addr (ds_wr_addr),
      .wr_data (ds_wr_data)
   );

   wtc_wbuf #(
      .AW    (ADDR_W),
      .DW    (DATA_W),
      .DEPTH (WBUF_DEPTH)
   ) i_wbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wb_push),
      .push_addr (cpu_addr),
      .push_data (cpu_wdata),
      .pop       (wb_pop),
      .full      (wb_full),
      .empty     (wb_empty),
      .head_addr (wb_head_addr),
      .head_data (wb_head_data)
   );

   // A line read may only leave while no store is buffered
   assert_fill_after_drain_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> wb_empty);

   // The memory request is held steady until acknowledged
   assert_req_held_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=>
         (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // Consecutive fill reads step by one word
   assert_fill_step_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack) |=>
         (!mem_req || (mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES))));

   // A completed load hit causes no memory read in its cycle
   assert_hit_quiet_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_we && cpu_ready) |-> !(mem_req && !mem_we));

   // The processor is never released while a line read is outstanding
   assert_stall_in_fill_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> !cpu_ready);

endmodule

// File: tb/test_wt_dcache.sv
module test_wt_dcache;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic        cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_ready;
   logic [31:0] cpu_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   int tests = 0;
   int fails = 0;
   int cyc = 0;

   // Memory model state
   logic [31:0] bmem [4096];
   int          mem_lat = 2;
   logic        mem_hold = 1'b0;
   int          wait_cnt = 0;
   logic [31:0] wlog_addr [64];
   logic [31:0] wlog_data [64];
   logic [31:0] rlog_addr [64];
   int          wcount = 0;
   int          rcount = 0;
   int          acc_writes = 0;
   int          viol8 = 0;
   int          viol9 = 0;
   logic        prev_wait = 1'b0;
   logic [31:0] prev_addr = '0;

   always #4 clk = ~clk;

   wt_dcache i_wt_dcache (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_req   (cpu_req),
      .cpu_we    (cpu_we),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .cpu_ready (cpu_ready),
      .cpu_rdata (cpu_rdata),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata)
   );

   initial begin
      for (int i = 0; i < 4096; i++) bmem[i] = 32'hD00D_0000 | (i << 2);
   end

   // Slow memory: acknowledges after mem_lat waiting cycles, one transfer at a time
   always @(posedge clk) begin
      mem_ack <= 1'b0;
      if (rst_n && mem_req && !mem_ack && !mem_hold) begin
         if (wait_cnt >= mem_lat) begin
            wait_cnt = 0;
            mem_ack <= 1'b1;
            if (mem_we) begin
               bmem[mem_addr[13:2]] = mem_wdata;
               if (wcount < 64) begin
                  wlog_addr[wcount] = mem_addr;
                  wlog_data[wcount] = mem_wdata;
               end
               wcount++;
            end else begin
               mem_rdata <= bmem[mem_addr[13:2]];
               if (rcount < 64) rlog_addr[rcount] = mem_addr;
               rcount++;
            end
         end else begin
            wait_cnt++;
         end
      end
   end

   // Port monitors for R8 and R9, sampled away from the clock edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req && !mem_we && (acc_writes != wcount)) viol8++;
         if (prev_wait && (!mem_req || mem_addr != prev_addr)) viol9++;
         prev_wait = mem_req && !mem_ack;
         prev_addr = mem_addr;
      end else begin
         prev_wait = 1'b0;
      end
   end

   // Watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   // One processor access; returns load data and the number of stalled cycles
   task automatic cpu_access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                             output logic [31:0] rd, output int stalls);
      @(negedge clk);
      cpu_req   = 1'b1;
      cpu_we    = we;
      cpu_addr  = addr;
      cpu_wdata = wd;
      stalls    = 0;
      #1;
      while (!cpu_ready && stalls < 5000) begin
         @(negedge clk);
         #1;
         stalls++;
      end
      rd = cpu_rdata;
      if (we) acc_writes++;
      @(posedge clk);
      #1;
      cpu_req = 1'b0;
      cpu_we  = 1'b0;
   endtask

   task automatic drain();
      int guard = 0;
      while (wcount != acc_writes && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      repeat (3) @(negedge clk);
   endtask

   // Vector: {we, expect_miss, addr, data}; for loads data is the expected word
   localparam int NV = 11;
   localparam logic [65:0] VEC [NV] = '{
      {1'b0, 1'b1, 32'h0000_0104, 32'hD00D_0104},  // cold miss, fill line 0x100
      {1'b0, 1'b0, 32'h0000_0108, 32'hD00D_0108},  // hit, other word
      {1'b1, 1'b0, 32'h0000_0108, 32'h1111_1111},  // store hit
      {1'b0, 1'b0, 32'h0000_0108, 32'h1111_1111},  // updated word
      {1'b1, 1'b0, 32'h0000_0500, 32'h2222_2222},  // store miss, no allocate
      {1'b0, 1'b1, 32'h0000_2104, 32'hD00D_2104},  // same index, other tag
      {1'b0, 1'b1, 32'h0000_0108, 32'h1111_1111},  // evicted, refilled from memory
      {1'b0, 1'b1, 32'h0000_0500, 32'h2222_2222},  // store miss did not allocate
      {1'b0, 1'b0, 32'h0000_050C, 32'hD00D_050C},  // last word of new line
      {1'b0, 1'b0, 32'h0000_0100, 32'hD00D_0100},  // first word
      {1'b0, 1'b0, 32'h0000_010C, 32'hD00D_010C}   // last word
   };

   initial begin
      logic [31:0] rd;
      int          st;
      int          wbase;
      int          rc0;
      logic [31:0] rd_d;
      int          st_d;
      logic        stuck;

      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      chk("R1 no memory request in reset", 32'(mem_req), 32'd0);
      chk("R1 not ready in reset", 32'(cpu_ready), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 no memory request after reset", 32'(mem_req), 32'd0);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         logic [65:0] v;
         v = VEC[i];
         cpu_access(v[65], v[63:32], v[31:0], rd, st);
         if (v[65]) begin
            chk($sformatf("R7 store %0d accepted without stall", i), 32'(st), 32'd0);
         end else begin
            chk($sformatf("R3 R4 load %0d data", i), rd, v[31:0]);
            chk($sformatf("R1 R2 R6 load %0d miss flag", i), 32'(st > 0), 32'(v[64]));
         end
         if (i == 0) begin
            chk("R4 fill count", 32'(rcount), 32'd4);
            for (int k = 0; k < 4; k++)
               chk($sformatf("R4 fill order word %0d", k), rlog_addr[k], 32'h0000_0100 + 32'(4 * k));
         end
      end
      drain();
      chk("R5 table stores reached memory", 32'(wcount), 32'd2);
      chk("R5 first store address", wlog_addr[0], 32'h0000_0108);
      chk("R5 second store data", wlog_data[1], 32'h2222_2222);

      // R7: four pending stores fill the buffer, the fifth stalls
      wbase = wcount;
      mem_hold = 1'b1;
      for (int k = 0; k < 4; k++) begin
         cpu_access(1'b1, 32'h0000_3000 + 32'(4 * k), 32'h5555_0000 + 32'(k), rd, st);
         chk($sformatf("R7 store %0d with room", k), 32'(st), 32'd0);
      end
      @(negedge clk);
      cpu_req   = 1'b1;
      cpu_we    = 1'b1;
      cpu_addr  = 32'h0000_3010;
      cpu_wdata = 32'h5555_0004;
      stuck = 1'b1;
      for (int k = 0; k < 4; k++) begin
         #1;
         if (cpu_ready) stuck = 1'b0;
         @(negedge clk);
      end
      chk("R7 stall while four pending", 32'(stuck), 32'd1);
      mem_hold = 1'b0;
      st = 0;
      #1;
      while (!cpu_ready && st < 5000) begin
         @(negedge clk);
         #1;
         st++;
      end
      acc_writes++;
      @(posedge clk);
      #1;
      cpu_req = 1'b0;
      cpu_we  = 1'b0;
      drain();
      for (int k = 0; k < 5; k++) begin
         chk($sformatf("R5 order address %0d", k), wlog_addr[wbase + k], 32'h0000_3000 + 32'(4 * k));
         chk($sformatf("R5 order data %0d", k), wlog_data[wbase + k], 32'h5555_0000 + 32'(k));
      end

      // R8: read miss behind a buffered store to the same address
      mem_hold = 1'b1;
      cpu_access(1'b1, 32'h0000_0200, 32'h3333_3333, rd, st);
      rc0 = rcount;
      fork
         cpu_access(1'b0, 32'h0000_0200, 32'h0, rd_d, st_d);
         begin
            repeat (8) @(negedge clk);
            chk("R8 no line read while store pending", 32'(rcount), 32'(rc0));
            mem_hold = 1'b0;
         end
      join
      chk("R8 load sees buffered store", rd_d, 32'h3333_3333);
      chk("R8 load was a miss", 32'(st_d > 0), 32'd1);

      // Same-cycle push and pop with zero latency memory; store hits update the line
      mem_lat = 0;
      wbase = wcount;
      for (int k = 0; k < 4; k++) begin
         cpu_access(1'b1, 32'h0000_0100 + 32'(4 * k), 32'h4444_0000 + 32'(k), rd, st);
         chk($sformatf("R7 back-to-back store %0d", k), 32'(st), 32'd0);
      end
      cpu_access(1'b0, 32'h0000_0104, 32'h0, rd, st);
      chk("R6 store hit updated word", rd, 32'h4444_0001);
      chk("R6 read after store hit is a hit", 32'(st), 32'd0);
      drain();
      chk("R5 all back-to-back stores written", 32'(wcount - wbase), 32'd4);
      chk("R5 last back-to-back store", wlog_data[wbase + 3], 32'h4444_0003);

      // R1: reset in mid-run invalidates cached lines
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 quiet memory port in reset", 32'(mem_req), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      cpu_access(1'b0, 32'h0000_0104, 32'h0, rd, st);
      chk("R1 read after reset misses", 32'(st > 0), 32'd1);
      chk("R1 read after reset data", rd, 32'h4444_0001);

      // R9: address bits 1:0 ignored on a hit
      cpu_access(1'b0, 32'h0000_0107, 32'h0, rd, st);
      chk("R9 low address bits ignored", rd, 32'h4444_0001);

      chk("R8 monitor: line read with stores pending", 32'(viol8), 32'd0);
      chk("R9 monitor: request dropped or changed", 32'(viol9), 32'd0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule